// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block buffers outgoing audio samples between a CPU-side register bus and the frame formatter of a stereo serial audio link. Software writes sample words into a data register. Each stored entry is a 20-bit sample. Narrower samples are moved to the top of the 20-bit field and zero-filled below. A packed mode lets one bus word carry two 16-bit-lane samples, which halves the bus traffic for 12-bit and 16-bit audio.

The FIFO drains toward the codec side as left/right pairs, over a valid/ready handshake. A burst starts only once the FIFO is at least half full. The burst then runs on while the sink keeps accepting. Four status flags track the FIFO: empty, half-empty, full and a sticky underrun. They feed three raw interrupt sources, and a software enable mask gates these onto a single interrupt line.

Bus register select `wr_sel_i`:

| Code | Register |
|------|----------|
| 0 | control |
| 1 | data |
| 2 | interrupt clear |
| 3 | interrupt enable |

Control register bits:

| Bit(s) | Function |
|--------|----------|
| [0] | transmit enable |
| [1] | slot-3 select |
| [2] | slot-4 select |
| [4:3] | width code |
| [5] | packed mode request |

Top module: `tx_sample_fifo`

## Requirements
- R1: After reset, `status_o` reads 4'b0011. The bit order is [0] empty, [1] half-empty, [2] full, [3] underrun. `snk_valid_o` is low, the configuration is all zero and the interrupt enable mask is zero.
- R2: In normal mode, one accepted data write stores one sample. The sample is the write data shifted left and kept to 20 bits. The shift depends on the width code: code 0 (16-bit) shifts by 4, code 1 (18-bit) by 2, code 2 (20-bit) by 0, and code 3 (12-bit) by 8.
- R3: In packed mode (control bit 5 with width code 0 or 3), one data write stores two samples. Bits [15:0] are stored first and bits [31:16] second. Each is shifted left by 8 for code 3 and by 4 for code 0, and truncated to 20 bits. With width code 1 or 2, a packed request is ignored and the write behaves as in normal mode.
- R4: A normal write is accepted only while level < DEPTH. A packed write is accepted only while level + 2 < DEPTH. A rejected write stores nothing and changes no status flag.
- R5: A pair is offered (`snk_valid_o`) only when all of these hold: transmit is enabled, slot 3 or slot 4 is selected, and the level is at least 2. In addition, either the level is at least DEPTH/2 or the previous cycle moved a pair. The older sample appears on `snk_left_o` and the newer on `snk_right_o`.
- R6: While `snk_ready_i` is low, no pair leaves. A cycle that offers a pair but sees the sink not ready ends the burst. A new burst needs the level to be at least DEPTH/2 again.
- R7: An accepted write clears empty and underrun. It clears half-empty if the new level is at least DEPTH/2. It sets full if the new level equals DEPTH.
- R8: A drained pair clears full. It sets half-empty if the new level is at most DEPTH/2. It sets both empty and underrun if the new level is zero.
- R9: A write of 1 in bit 0 of the interrupt clear register clears underrun.
- R10: `raw_irq_o` is formed as follows: bit [0] is underrun, bit [1] is half-empty, and bit [2] is empty AND NOT `tx_busy_i`. `irq_o` is the OR of `raw_irq_o` AND the enable mask, whose bit order is the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | bus write strobe |
| wr_sel_i | input | 2 | register select |
| wr_data_i | input | 32 | bus write data |
| tx_busy_i | input | 1 | frame formatter still shifting out |
| snk_ready_i | input | 1 | sink accepts a pair this cycle |
| snk_valid_o | output | 1 | pair offered |
| snk_left_o | output | 20 | older sample of the pair |
| snk_right_o | output | 20 | newer sample of the pair |
| status_o | output | 4 | {underrun, full, half-empty, empty} |
| raw_irq_o | output | 3 | {complete, half-empty, underrun} |
| irq_o | output | 1 | masked interrupt line |

## Verification
The bench builds the block with DEPTH = 8. At that depth a handful of writes reaches every threshold: half at 4, packed rejection at 6 and full at 8. This makes it cheap to sweep all four width codes, with packed mode both requested and forced off. It also drives writes past both rejection limits and pulses the sink ready line mid-burst, so the burst can be seen ending below half depth. Every sample value is recomputed in the bench from the width code and shift rules, and compared pair by pair as the FIFO drains.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  localparam int unsigned SAMPLE_W = 20;
  localparam int unsigned BUS_W    = 32;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_ICLR = 2'd2;
  localparam logic [1:0] SEL_IEN  = 2'd3;

  typedef enum logic [1:0] {
    SZ_16 = 2'd0,
    SZ_18 = 2'd1,
    SZ_20 = 2'd2,
    SZ_12 = 2'd3
  } size_e;

  typedef struct packed {
    logic  compact;
    size_e size;
    logic  slot4;
    logic  slot3;
    logic  en;
  } tx_cfg_t;

  typedef struct packed {
    logic underrun;
    logic full;
    logic half;
    logic empty;
  } tx_stat_t;
endpackage

// File: rtl/sample_packer.sv
module sample_packer
  import tx_fifo_pkg::*;
(
  input  logic [BUS_W-1:0]              data_i,
  input  size_e                         size_i,
  input  logic                          compact_i,
  output logic [1:0][SAMPLE_W-1:0]      lane_o,
  output logic                          two_o
);
  // packing only legal for 12/16-bit widths
  assign two_o = compact_i && (size_i == SZ_16 || size_i == SZ_12);

  always_comb begin
    lane_o = '0;
    if (two_o) begin
      if (size_i == SZ_12) begin
        lane_o[0] = {data_i[11:0], 8'b0};
        lane_o[1] = {data_i[27:16], 8'b0};
      end else begin
        lane_o[0] = {data_i[15:0], 4'b0};
        lane_o[1] = {data_i[31:16], 4'b0};
      end
    end else begin
      unique case (size_i)
        SZ_12:   lane_o[0] = {data_i[11:0], 8'b0};
        SZ_16:   lane_o[0] = {data_i[15:0], 4'b0};
        SZ_18:   lane_o[0] = {data_i[17:0], 2'b0};
        default: lane_o[0] = data_i[19:0];
      endcase
    end
  end
endmodule

// File: rtl/sample_store.sv
module sample_store
  import tx_fifo_pkg::*;
#(
  parameter  int unsigned DEPTH  = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          push_i,
  input  logic                          two_i,
  input  logic [1:0][SAMPLE_W-1:0]      lane_i,
  input  logic                          pop_i,
  output logic [1:0][SAMPLE_W-1:0]      head_o
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]   wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + (two_i ? ADDR_W'(2) : ADDR_W'(1));
      if (pop_i)  rd_ptr_q <= rd_ptr_q + ADDR_W'(2);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < 2; l++) begin
      if (push_i && (l == 0 || two_i)) mem[wr_ptr_q + ADDR_W'(l)] <= lane_i[l];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_head
    assign head_o[g] = mem[rd_ptr_q + ADDR_W'(g)];
  end
endmodule

// File: rtl/tx_status.sv
module tx_status
  import tx_fifo_pkg::*;
#(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             clr_und_i,
  input  logic [LVL_W-1:0] nlevel_i,
  input  logic             tx_busy_i,
  input  logic [2:0]       ien_i,
  output tx_stat_t         stat_o,
  output logic [2:0]       raw_o,
  output logic             irq_o
);
  localparam int unsigned HALF = DEPTH / 2;

  tx_stat_t stat_q, stat_d;

  // write effects first, drain effects override
  always_comb begin
    stat_d = stat_q;
    if (push_i) begin
      stat_d.empty    = 1'b0;
      stat_d.underrun = 1'b0;
      if (32'(nlevel_i) >= HALF)  stat_d.half = 1'b0;
      if (32'(nlevel_i) == DEPTH) stat_d.full = 1'b1;
    end
    if (clr_und_i) stat_d.underrun = 1'b0;
    if (pop_i) begin
      stat_d.full = 1'b0;
      if (32'(nlevel_i) <= HALF) stat_d.half = 1'b1;
      if (nlevel_i == '0) begin
        stat_d.empty    = 1'b1;
        stat_d.underrun = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '{underrun: 1'b0, full: 1'b0, half: 1'b1, empty: 1'b1};
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign raw_o  = {stat_q.empty & ~tx_busy_i, stat_q.half, stat_q.underrun};
  assign irq_o  = |(raw_o & ien_i);
endmodule

// File: rtl/tx_sample_fifo.sv
module tx_sample_fifo
  import tx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [BUS_W-1:0]    wr_data_i,
  input  logic                tx_busy_i,
  input  logic                snk_ready_i,
  output logic                snk_valid_o,
  output logic [SAMPLE_W-1:0] snk_left_o,
  output logic [SAMPLE_W-1:0] snk_right_o,
  output logic [3:0]          status_o,
  output logic [2:0]          raw_irq_o,
  output logic                irq_o
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned LVL_W  = ADDR_W + 1;
  localparam int unsigned HALF   = DEPTH / 2;

  tx_cfg_t                  cfg_q;
  logic [2:0]               ien_q;
  logic [LVL_W-1:0]         level_q, level_d;
  logic                     burst_q;
  logic [1:0][SAMPLE_W-1:0] lanes, head;
  logic                     pair_w, data_wr, accept, pop, clr_und;
  tx_stat_t                 stat;

  assign data_wr = wr_en_i && wr_sel_i == SEL_DATA;
  assign clr_und = wr_en_i && wr_sel_i == SEL_ICLR && wr_data_i[0];

  sample_packer u_pack (
    .data_i    (wr_data_i),
    .size_i    (cfg_q.size),
    .compact_i (cfg_q.compact),
    .lane_o    (lanes),
    .two_o     (pair_w)
  );

  assign accept = data_wr &&
                  (pair_w ? (32'(level_q) + 32'd2 < DEPTH) : (32'(level_q) < DEPTH));

  // burst opens at half depth, survives only while sink keeps accepting
  assign snk_valid_o = cfg_q.en && (cfg_q.slot3 || cfg_q.slot4) &&
                       (32'(level_q) >= 32'd2) &&
                       ((32'(level_q) >= HALF) || burst_q);
  assign pop = snk_valid_o && snk_ready_i;

  assign level_d = level_q
                 + (accept ? (pair_w ? LVL_W'(2) : LVL_W'(1)) : LVL_W'(0))
                 - (pop ? LVL_W'(2) : LVL_W'(0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      ien_q   <= '0;
      level_q <= '0;
      burst_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_sel_i == SEL_CTRL) cfg_q <= tx_cfg_t'(wr_data_i[5:0]);
      if (wr_en_i && wr_sel_i == SEL_IEN)  ien_q <= wr_data_i[2:0];
      level_q <= level_d;
      burst_q <= pop;
    end
  end

  sample_store #(.DEPTH(DEPTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (accept),
    .two_i  (pair_w),
    .lane_i (lanes),
    .pop_i  (pop),
    .head_o (head)
  );

  assign snk_left_o  = head[0];
  assign snk_right_o = head[1];

  tx_status #(.DEPTH(DEPTH)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (accept),
    .pop_i     (pop),
    .clr_und_i (clr_und),
    .nlevel_i  (level_d),
    .tx_busy_i (tx_busy_i),
    .ien_i     (ien_q),
    .stat_o    (stat),
    .raw_o     (raw_irq_o),
    .irq_o     (irq_o)
  );

  assign status_o = stat;
endmodule

// File: rtl/tx_fifo_chk.sv
module tx_fifo_chk
  import tx_fifo_pkg::*;
#(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic             snk_valid_o,
  input logic             snk_ready_i,
  input logic [3:0]       status_o,
  input logic [LVL_W-1:0] level_q,
  input logic             cfg_en
);
  logic data_wr;
  assign data_wr = wr_en_i && wr_sel_i == SEL_DATA;

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(level_q) <= DEPTH);

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_valid_o && !snk_ready_i && !data_wr |=> $stable(level_q));

  // R8
  drain_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_valid_o && snk_ready_i && level_q == LVL_W'(2) && !data_wr
    |=> status_o[0] && status_o[3]);

  // R7
  full_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] |-> 32'(level_q) == DEPTH);

  // R5
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_valid_o |-> cfg_en && level_q >= LVL_W'(2));

  // R7
  first_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && level_q == '0 |=> !status_o[0]);
endmodule

bind tx_sample_fifo tx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .snk_valid_o (snk_valid_o),
  .snk_ready_i (snk_ready_i),
  .status_o    (status_o),
  .level_q     (level_q),
  .cfg_en      (cfg_q.en)
);

// File: tb/sim_tx_sample_fifo.sv
`timescale 1ns/100ps
module sim_tx_sample_fifo;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        tx_busy = 1'b0;
  logic        snk_ready = 1'b0;
  logic        snk_valid;
  logic [19:0] snk_left, snk_right;
  logic [3:0]  status;
  logic [2:0]  raw_irq;
  logic        irq;

  always #2.5 clk = ~clk;

  tx_sample_fifo #(.DEPTH(D)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .tx_busy_i(tx_busy), .snk_ready_i(snk_ready),
    .snk_valid_o(snk_valid), .snk_left_o(snk_left), .snk_right_o(snk_right),
    .status_o(status), .raw_irq_o(raw_irq), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  int tb_level = 0, wr_idx = 0, rd_idx = 0;
  int tb_sz = 0;
  bit tb_cmp = 1'b0;
  string cur_req = "R2";
  logic [19:0] exp_buf [0:255];
  logic [31:0] pat = 32'h1234_5678;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(input bit en, input bit s3, input bit s4,
                                       input int sz, input bit cmp);
    return {26'b0, cmp, 2'(sz), s4, s3, en};
  endfunction

  function automatic int nshift(input int sz);
    case (sz)
      0: return 4;
      1: return 2;
      2: return 0;
      default: return 8;
    endcase
  endfunction

  task automatic bus_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_word();
    logic [31:0] t;
    bit two;
    pat = pat * 32'd1664525 + 32'd1013904223;
    two = tb_cmp && (tb_sz == 0 || tb_sz == 3);
    if (two) begin
      if (tb_level + 2 < D) begin
        t = {16'b0, pat[15:0]} << ((tb_sz == 3) ? 8 : 4);
        exp_buf[wr_idx] = t[19:0];
        t = {16'b0, pat[31:16]} << ((tb_sz == 3) ? 8 : 4);
        exp_buf[wr_idx+1] = t[19:0];
        wr_idx += 2; tb_level += 2;
      end
    end else if (tb_level < D) begin
      t = pat << nshift(tb_sz);
      exp_buf[wr_idx] = t[19:0];
      wr_idx++; tb_level++;
    end
    bus_wr(2'd1, pat);
  endtask

  // pair monitor: predicts the transfer at the coming edge
  always @(negedge clk) begin
    #1;
    if (rst_n && snk_valid && snk_ready) begin
      if (rd_idx + 1 >= wr_idx) begin
        chk(cur_req, {31'b0, 1'b1}, 32'd0);
      end else begin
        chk(cur_req, {12'b0, snk_left},  {12'b0, exp_buf[rd_idx]});
        chk(cur_req, {12'b0, snk_right}, {12'b0, exp_buf[rd_idx+1]});
      end
      rd_idx += 2; tb_level -= 2;
    end
  end

  task automatic drain_all();
    @(negedge clk);
    snk_ready = 1'b1;
    repeat (D + 4) @(negedge clk);
    snk_ready = 1'b0;
    chk("R5", 32'(rd_idx), 32'(wr_idx));
  endtask

  task automatic after_drain(input int sz);
    chk("R8", {28'b0, status}, 32'hB);
    chk("R10", {29'b0, raw_irq}, 32'h7);
    chk("R10", {31'b0, irq}, 32'd1);
    bus_wr(2'd2, 32'd1);
    chk("R9", {28'b0, status}, 32'h3);
    chk("R10", {31'b0, irq}, 32'd0);
    bus_wr(2'd0, ctrl(1'b1, 1'b0, 1'b0, sz, 1'b0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R5 watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {28'b0, status}, 32'h3);
    chk("R1", {31'b0, snk_valid}, 32'd0);
    chk("R10", {29'b0, raw_irq}, 32'h6);
    chk("R1", {31'b0, irq}, 32'd0);
    bus_wr(2'd3, 32'h7);
    chk("R10", {31'b0, irq}, 32'd1);
    bus_wr(2'd3, 32'h1);
    chk("R10", {31'b0, irq}, 32'd0);

    // normal mode, every width code
    cur_req = "R2";
    for (int sz = 0; sz < 4; sz++) begin
      tb_sz = sz; tb_cmp = 1'b0;
      bus_wr(2'd0, ctrl(1'b1, 1'b0, 1'b0, sz, 1'b0));
      for (int k = 0; k < 4; k++) begin
        push_word();
        if (k == 2) chk("R7", {28'b0, status}, 32'h2);
      end
      chk("R7", {28'b0, status}, 32'h0);
      bus_wr(2'd0, ctrl(1'b0, 1'b1, 1'b1, sz, 1'b0));
      chk("R5", {31'b0, snk_valid}, 32'd0);
      bus_wr(2'd0, ctrl(1'b1, sz[0] == 1'b0, sz[0] == 1'b1, sz, 1'b0));
      chk("R5", {31'b0, snk_valid}, 32'd1);
      drain_all();
      after_drain(sz);
    end

    // packed mode, widths where it applies
    cur_req = "R3";
    for (int i = 0; i < 2; i++) begin
      tb_sz = (i == 0) ? 0 : 3; tb_cmp = 1'b1;
      bus_wr(2'd0, ctrl(1'b1, 1'b0, 1'b0, tb_sz, 1'b1));
      push_word(); push_word();
      chk("R3", {28'b0, status}, 32'h0);
      bus_wr(2'd0, ctrl(1'b1, 1'b1, 1'b0, tb_sz, 1'b1));
      drain_all();
      after_drain(tb_sz);
    end

    // packed request ignored for 18/20-bit
    for (int sz = 1; sz < 3; sz++) begin
      tb_sz = sz; tb_cmp = 1'b1;
      bus_wr(2'd0, ctrl(1'b1, 1'b0, 1'b0, sz, 1'b1));
      push_word(); push_word();
      chk("R3", {28'b0, status}, 32'h2);
      push_word(); push_word();
      chk("R3", {28'b0, status}, 32'h0);
      bus_wr(2'd0, ctrl(1'b1, 1'b0, 1'b1, sz, 1'b1));
      drain_all();
      after_drain(sz);
    end

    // overflow drop, normal
    cur_req = "R4";
    tb_sz = 0; tb_cmp = 1'b0;
    bus_wr(2'd0, ctrl(1'b1, 1'b0, 1'b0, 0, 1'b0));
    for (int k = 0; k < 10; k++) begin
      push_word();
      if (k == 7) chk("R7", {28'b0, status}, 32'h4);
    end
    chk("R4", {28'b0, status}, 32'h4);
    chk("R4", 32'(wr_idx - rd_idx), 32'd8);
    bus_wr(2'd0, ctrl(1'b1, 1'b1, 1'b0, 0, 1'b0));
    drain_all();
    after_drain(0);

    // overflow drop, packed: level stops at DEPTH-2
    tb_cmp = 1'b1;
    bus_wr(2'd0, ctrl(1'b1, 1'b0, 1'b0, 0, 1'b1));
    for (int k = 0; k < 4; k++) push_word();
    chk("R4", {28'b0, status}, 32'h0);
    chk("R4", 32'(wr_idx - rd_idx), 32'd6);
    bus_wr(2'd0, ctrl(1'b1, 1'b1, 1'b0, 0, 1'b1));
    drain_all();
    after_drain(0);

    // sink back-pressure mid-drain
    cur_req = "R6";
    tb_sz = 2; tb_cmp = 1'b0;
    bus_wr(2'd0, ctrl(1'b1, 1'b0, 1'b0, 2, 1'b0));
    for (int k = 0; k < 8; k++) push_word();
    bus_wr(2'd0, ctrl(1'b1, 1'b1, 1'b1, 2, 1'b0));
    repeat (5) @(negedge clk);
    chk("R6", {31'b0, snk_valid}, 32'd1);
    chk("R6", {28'b0, status}, 32'h4);
    snk_ready = 1'b1; @(negedge clk); snk_ready = 1'b0;
    chk("R8", {28'b0, status}, 32'h0);
    chk("R6", {31'b0, snk_valid}, 32'd1);
    snk_ready = 1'b1; @(negedge clk); snk_ready = 1'b0;
    chk("R8", {28'b0, status}, 32'h2);
    snk_ready = 1'b1; @(negedge clk); snk_ready = 1'b0;
    @(negedge clk);
    chk("R6", {31'b0, snk_valid}, 32'd0);
    snk_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6", {31'b0, snk_valid}, 32'd0);
    chk("R6", {28'b0, status}, 32'h2);
    chk("R6", 32'(wr_idx - rd_idx), 32'd2);
    push_word(); push_word();
    repeat (D) @(negedge clk);
    snk_ready = 1'b0;
    chk("R6", 32'(rd_idx), 32'(wr_idx));
    chk("R8", {28'b0, status}, 32'hB);

    // completion interrupt gated by busy
    bus_wr(2'd2, 32'd1);
    tx_busy = 1'b1;
    @(negedge clk);
    chk("R10", {29'b0, raw_irq}, 32'h2);
    bus_wr(2'd3, 32'h4);
    chk("R10", {31'b0, irq}, 32'd0);
    tx_busy = 1'b0;
    @(negedge clk);
    chk("R10", {31'b0, irq}, 32'd1);
    bus_wr(2'd3, 32'h2);
    chk("R10", {31'b0, irq}, 32'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule